// File: doc/BRIEF.md
# First-Hit Group Arbiter with Pileup Logging

This block lets a small group of pixel hit lines share one time-measurement channel. The earliest rising hit in the group wins the channel. Its pixel address is frozen, and its hit is passed on to the shared time-to-digital converter (TDC). The block then stays busy for a window made of two parts: the winner's time over threshold, followed by a programmable acquisition time. Any hit that rises in the group during that window does not get the channel. Instead it is recorded in a pileup mask, one bit per pixel.

The arbiter is modelled synchronously on a fast sampling clock, and the hit lines are sampled on that clock. A line counts as a new hit only on a sampled low-to-high transition. When the window closes, the block presents the winning address and the pileup mask together with a one-cycle done pulse. It then clears both and is ready for the next hit.

Top module: `hit_group_arbiter`

## Requirements
- R1: After reset, busy_o, done_o and tdc_hit_o are 0, and win_addr_o and pileup_o are all zero.
- R2: When a single hit line k rises while the block is idle, from the next clock edge busy_o is 1, tdc_hit_o is 1 and win_addr_o equals k. win_addr_o is the binary index of the line, with line 0 at bit 0 of hit_i.
- R3: When several lines rise in the same sampled cycle, the lowest index wins. Every other line rising in that cycle sets its own bit in pileup_o, where bit k stands for line k.
- R4: win_addr_o holds the winner's address unchanged for as long as busy_o stays high, whatever other lines do.
- R5: A line that rises while busy_o is high sets its pileup_o bit. Bits in pileup_o are never cleared while busy_o stays high.
- R6: tdc_hit_o is high from the cycle the window opens until the clock edge at which the winner's line is sampled low. At that edge tdc_hit_o drops to 0.
- R7: After the winner's line is sampled low, busy_o stays high for exactly acq_cycles_i further cycles. A value of 0 ends the window at the same edge that samples the line low.
- R8: At the edge that closes the window, done_o pulses high for exactly one cycle, with the final win_addr_o and pileup_o and with busy_o low. One cycle later win_addr_o and pileup_o are zero.
- R9: A line that is still high when the window closes does not start a new window. It can win again only after it has gone low and risen again.
- R10: A line that is already high when reset is released does not start a window until it has gone low and risen again.
- R11: A hit that rises during the done cycle is arbitrated like a hit arriving while idle, and it opens a new window at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hit_i | input | NUM_PIX (5) | Discriminated hit line of each pixel in the group |
| acq_cycles_i | input | CNT_W (8) | TDC acquisition time, counted in clock cycles after the winner's line falls |
| busy_o | output | 1 | The shared channel is held by a winner |
| tdc_hit_o | output | 1 | The winner's hit, forwarded to the TDC |
| win_addr_o | output | ADDR_W (3) | Address of the winning pixel |
| pileup_o | output | NUM_PIX (5) | Pixels that rose during the busy window |
| done_o | output | 1 | One-cycle pulse when the window closes and the results are valid |

## Verification
Some properties can be checked on every cycle, and the assertions cover them. The winner's address stays stable while busy_o is high. The pileup mask only gains bits during a window. tdc_hit_o is never high without busy_o. done_o is a single-cycle pulse that comes exactly when busy_o falls. Other behaviour depends on particular stimulus sequences, and only the bench's directed scenarios show it. These are the priority order among hits in the same cycle, the exact length of the acquisition window for a given count, and clearing after the done cycle. They also include the refusal to re-arbitrate a line that is held high across the window's end or across reset, and the restart when a hit rises during the done cycle.

// File: rtl/hga_pkg.sv
package hga_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TOT    = 2'd1,
        ST_ACQ    = 2'd2,
        ST_REPORT = 2'd3
    } hga_state_e;

endpackage

// File: rtl/hga_rise_det.sv
module hga_rise_det #(
    parameter int NUM_PIX = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_PIX-1:0] lvl_i,
    output logic [NUM_PIX-1:0] rise_o
);
    // Reset to all ones so a line already high out of reset needs a fresh edge.
    logic [NUM_PIX-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '1;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/hga_first_pick.sv
module hga_first_pick #(
    parameter int NUM_PIX = 5,
    parameter int ADDR_W  = $clog2(NUM_PIX)
) (
    input  logic [NUM_PIX-1:0] req_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  idx_o,
    output logic [NUM_PIX-1:0] onehot_o
);
    // Scan from the top down so the lowest requesting index is the last write.
    always_comb begin
        valid_o  = |req_i;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = NUM_PIX - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o    = ADDR_W'(i);
                onehot_o = NUM_PIX'(1) << i;
            end
        end
    end

endmodule

// File: rtl/hit_group_arbiter.sv
module hit_group_arbiter
    import hga_pkg::*;
#(
    parameter int NUM_PIX = 5,
    parameter int CNT_W   = 8,
    localparam int ADDR_W = $clog2(NUM_PIX)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_PIX-1:0] hit_i,
    input  logic [CNT_W-1:0]   acq_cycles_i,
    output logic               busy_o,
    output logic               tdc_hit_o,
    output logic [ADDR_W-1:0]  win_addr_o,
    output logic [NUM_PIX-1:0] pileup_o,
    output logic               done_o
);

    typedef struct packed {
        hga_state_e         state;
        logic [ADDR_W-1:0]  addr;
        logic [NUM_PIX-1:0] pile;
        logic [CNT_W-1:0]   cnt;
    } hga_regs_t;

    hga_regs_t s_d, s_q;

    logic [NUM_PIX-1:0] rise;
    logic               pick_valid;
    logic [ADDR_W-1:0]  pick_idx;
    logic [NUM_PIX-1:0] pick_onehot;

    hga_rise_det #(.NUM_PIX(NUM_PIX)) u_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (hit_i),
        .rise_o (rise)
    );

    hga_first_pick #(.NUM_PIX(NUM_PIX), .ADDR_W(ADDR_W)) u_pick (
        .req_i    (rise),
        .valid_o  (pick_valid),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE, ST_REPORT: begin
                // Results are cleared after the report cycle; a new rise opens a window.
                s_d.state = ST_IDLE;
                s_d.addr  = '0;
                s_d.pile  = '0;
                s_d.cnt   = '0;
                if (pick_valid) begin
                    s_d.state = ST_TOT;
                    s_d.addr  = pick_idx;
                    s_d.pile  = rise & ~pick_onehot;
                end
            end
            ST_TOT: begin
                s_d.pile = s_q.pile | rise;
                if (!hit_i[s_q.addr]) begin
                    if (acq_cycles_i == '0) begin
                        s_d.state = ST_REPORT;
                    end else begin
                        s_d.state = ST_ACQ;
                        s_d.cnt   = acq_cycles_i - 1'b1;
                    end
                end
            end
            ST_ACQ: begin
                s_d.pile = s_q.pile | rise;
                if (s_q.cnt == '0) s_d.state = ST_REPORT;
                else               s_d.cnt   = s_q.cnt - 1'b1;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.state <= ST_IDLE;
            s_q.addr  <= '0;
            s_q.pile  <= '0;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy_o     = (s_q.state == ST_TOT) || (s_q.state == ST_ACQ);
        tdc_hit_o  = (s_q.state == ST_TOT);
        done_o     = (s_q.state == ST_REPORT);
        win_addr_o = s_q.addr;
        pileup_o   = s_q.pile;
    end

endmodule

// File: rtl/hga_checker.sv
module hga_checker #(
    parameter int NUM_PIX = 5,
    parameter int ADDR_W  = $clog2(NUM_PIX)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               busy_o,
    input logic               tdc_hit_o,
    input logic [ADDR_W-1:0]  win_addr_o,
    input logic [NUM_PIX-1:0] pileup_o,
    input logic               done_o
);

    // R2
    addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(win_addr_o) < NUM_PIX));

    // R4
    addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(win_addr_o));

    // R5
    pile_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ((pileup_o & $past(pileup_o)) == $past(pileup_o)));

    // R6
    tdc_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tdc_hit_o |-> busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    done_at_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

endmodule

bind hit_group_arbiter hga_checker #(.NUM_PIX(NUM_PIX)) u_hga_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_o     (busy_o),
    .tdc_hit_o  (tdc_hit_o),
    .win_addr_o (win_addr_o),
    .pileup_o   (pileup_o),
    .done_o     (done_o)
);

// File: tb/sim_hit_group_arbiter.sv
module sim_hit_group_arbiter;

    localparam int NP = 5;
    localparam int CW = 8;
    localparam int AW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] hit;
    logic [CW-1:0] acq;
    logic          busy, tdc, done;
    logic [AW-1:0] addr;
    logic [NP-1:0] pile;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hit_group_arbiter #(.NUM_PIX(NP), .CNT_W(CW)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hit_i        (hit),
        .acq_cycles_i (acq),
        .busy_o       (busy),
        .tdc_hit_o    (tdc),
        .win_addr_o   (addr),
        .pileup_o     (pile),
        .done_o       (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [NP-1:0] v);
        @(negedge clk);
        hit = v;
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 done", int'(done), 0);
        chk_eq("R1 tdc", int'(tdc), 0);
        chk_eq("R1 addr", int'(addr), 0);
        chk_eq("R1 pile", int'(pile), 0);
    endtask

    // R2 R6 R7 R8: one hit, window length set by acq = 3
    task automatic t_single(input int k);
        acq = 8'd3;
        drive(NP'(1) << k);
        step(1);
        chk_eq("R2 busy", int'(busy), 1);
        chk_eq("R2 addr", int'(addr), k);
        chk_eq("R6 tdc high", int'(tdc), 1);
        chk_eq("R2 pile", int'(pile), 0);
        drive('0);
        step(1);
        chk_eq("R6 tdc low", int'(tdc), 0);
        chk_eq("R7 busy in acq", int'(busy), 1);
        step(2);
        chk_eq("R7 busy last acq", int'(busy), 1);
        step(1);
        chk_eq("R7 busy end", int'(busy), 0);
        chk_eq("R8 done", int'(done), 1);
        chk_eq("R8 addr", int'(addr), k);
        step(1);
        chk_eq("R8 done pulse", int'(done), 0);
        chk_eq("R8 addr cleared", int'(addr), 0);
        chk_eq("R8 pile cleared", int'(pile), 0);
    endtask

    // R3: simultaneous rises on lines 1, 2 and 4
    task automatic t_simul();
        acq = 8'd2;
        drive(5'b10110);
        step(1);
        chk_eq("R3 winner", int'(addr), 1);
        chk_eq("R3 pile", int'(pile), 'b10100);
        drive('0);
        step(3);
        chk_eq("R3 done", int'(done), 1);
        chk_eq("R3 final pile", int'(pile), 'b10100);
        step(1);
    endtask

    // R4 R5 R9: later hits during TOT and ACQ, line 0 held across close
    task automatic t_pileup();
        acq = 8'd3;
        drive(5'b01000);
        step(1);
        drive(5'b01001);
        step(1);
        chk_eq("R4 addr frozen", int'(addr), 3);
        chk_eq("R5 pile tot", int'(pile), 'b00001);
        drive(5'b00001);
        step(1);
        drive(5'b10001);
        step(1);
        chk_eq("R5 pile acq", int'(pile), 'b10001);
        chk_eq("R4 addr acq", int'(addr), 3);
        drive(5'b00001);
        step(2);
        chk_eq("R5 done", int'(done), 1);
        chk_eq("R5 final pile", int'(pile), 'b10001);
        step(3);
        chk_eq("R9 no rearb busy", int'(busy), 0);
        chk_eq("R9 no rearb addr", int'(addr), 0);
        drive('0);
        drive(5'b00001);
        step(1);
        chk_eq("R9 fresh rise busy", int'(busy), 1);
        chk_eq("R9 fresh rise addr", int'(addr), 0);
        drive('0);
        step(5);
    endtask

    // R7: zero acquisition time
    task automatic t_zero_acq();
        acq = 8'd0;
        drive(5'b00100);
        step(1);
        drive('0);
        step(1);
        chk_eq("R7 zero acq done", int'(done), 1);
        chk_eq("R7 zero acq busy", int'(busy), 0);
        chk_eq("R7 zero acq addr", int'(addr), 2);
        step(1);
    endtask

    // R11: rise during the done cycle starts a new window
    task automatic t_restart();
        acq = 8'd1;
        drive(5'b00010);
        step(1);
        drive('0);
        step(2);
        chk_eq("R11 done seen", int'(done), 1);
        drive(5'b00100);
        step(1);
        chk_eq("R11 new busy", int'(busy), 1);
        chk_eq("R11 new addr", int'(addr), 2);
        chk_eq("R11 new pile", int'(pile), 0);
        drive('0);
        step(4);
    endtask

    // R10: line held high through reset release
    task automatic t_reset_high();
        @(negedge clk);
        rst_n = 1'b0;
        hit   = 5'b00100;
        step(2);
        @(negedge clk);
        rst_n = 1'b1;
        step(3);
        chk_eq("R10 no start busy", int'(busy), 0);
        drive('0);
        drive(5'b00100);
        step(1);
        chk_eq("R10 fresh busy", int'(busy), 1);
        chk_eq("R10 fresh addr", int'(addr), 2);
        drive('0);
        step(4);
    endtask

    initial begin
        rst_n = 1'b0;
        hit   = '0;
        acq   = 8'd3;
        step(3);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_single(4);
        t_single(0);
        t_simul();
        t_pileup();
        t_zero_acq();
        t_restart();
        t_reset_high();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule